// File: doc/BRIEF.md
# Programmable GPIO Input Debounce Filter

This block cleans up one general-purpose input pin before the rest of the chip sees it. The raw pin is first brought into the core clock domain through a short flop chain. It is then filtered against a timeout measured in ticks of a slow real-time clock. The tick arrives as a one-cycle enable on the core clock. The timeout is a 4-bit count multiplied by one of four tick units, chosen by a range bit and a unit bit.

Four filter types are available. Bypass passes the synchronised level straight through. Remove-glitch debounces both edges. The two preserve types let pulses of one polarity through at once and debounce only the return edge. If the count field is left at zero while a filtering type is chosen, the block falls back to a built-in default setup. After reset the output takes the pin level with no debounce history, so the first valid level is not delayed by a full timeout.

Top module: `gpio_debounce`

## Requirements
- R1: With type code 0 (bypass), `pin_out` equals `pin_raw` as sampled three clock edges earlier, so pulses of any length pass through.
- R2: The timeout is `db_count` times a tick unit chosen by {`db_range_sel`,`db_unit_sel`}: 00 gives 2 ticks, 01 gives 8, 10 gives 512 and 11 gives 2048. The maximum is 15 × 2048 = 30720 ticks.
- R3: With type code 3 (remove glitches), `pin_out` moves to a new level only after the synchronised input has held that level for the full timeout, in both directions. An excursion shorter than the timeout leaves `pin_out` unchanged.
- R4: A return of the input to the current output level during the timeout clears the tick count, so a later change needs the full timeout again.
- R5: With type code 1 (keep low pulses), a falling input reaches `pin_out` on the third edge with no debounce, and a rising input is debounced for the full timeout.
- R6: With type code 2 (keep high pulses), a rising input reaches `pin_out` on the third edge with no debounce, and a falling input is debounced for the full timeout.
- R7: With a nonzero type and `db_count` = 0, the block uses count 15, unit 8 ticks and the remove-glitch type, whatever type was requested.
- R8: While `rst` is high, `pin_out` is 0. After `rst` falls, `pin_out` takes the input level by the third edge with no debounce.
- R9: The timeout advances only on cycles with `rtc_tick` high. Without ticks, a debounced change never completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | 1 | Asynchronous pin level |
| rtc_tick | input | 1 | One-cycle enable per slow-clock tick |
| db_count | input | 4 | Timeout count in units (0 selects the default setup) |
| db_unit_sel | input | 1 | Chooses the smaller or larger unit within a range |
| db_range_sel | input | 1 | Chooses the short or long unit range |
| db_type | input | 2 | Filter type: 0 bypass, 1 keep low pulses, 2 keep high pulses, 3 remove glitches |
| pin_out | output | 1 | Filtered pin level |

## Verification
An immediate change (bypass, or the passing polarity of a preserve type) shows on `pin_out` at the third rising edge after `pin_raw` moves. With the tick held high, a debounced change with timeout N ticks shows at edge N+2. This is two edges of synchronisation followed by N counted ticks. Every check drives inputs on a falling edge and counts falling edges afterwards. It confirms the old level one edge before the due edge and the new level at the due edge. For glitch, restart and no-tick cases it checks that the level has not moved well past the edge where a wrong design would have switched.

// File: rtl/gpio_db_pkg.sv
package gpio_db_pkg;

    localparam int DB_CNT_W = 4;

    typedef enum logic [1:0] {
        FLT_BYPASS    = 2'd0,
        FLT_KEEP_LOW  = 2'd1,
        FLT_KEEP_HIGH = 2'd2,
        FLT_REMOVE    = 2'd3
    } flt_mode_e;

    typedef struct packed {
        logic [DB_CNT_W-1:0] count;
        logic                unit_sel;
        logic                range_sel;
        flt_mode_e           mode;
    } db_setup_t;

    // fallback used when a filtering type is requested with a zero count
    localparam logic [DB_CNT_W-1:0] DEF_COUNT = '1;
    localparam logic                DEF_UNIT  = 1'b1;
    localparam logic                DEF_RANGE = 1'b0;

    function automatic int unit_ticks(input logic range_sel, input logic unit_sel,
                                      input int t0, input int t1,
                                      input int t2, input int t3);
        case ({range_sel, unit_sel})
            2'b00:   return t0;
            2'b01:   return t1;
            2'b10:   return t2;
            default: return t3;
        endcase
    endfunction

    // true when the given input level bypasses the timeout in this mode
    function automatic logic passes_now(input flt_mode_e m, input logic lvl);
        case (m)
            FLT_BYPASS:    return 1'b1;
            FLT_KEEP_LOW:  return !lvl;
            FLT_KEEP_HIGH: return lvl;
            default:       return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/gpio_db_sync.sv
module gpio_db_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain_q[0] <= 1'b0;
                else     chain_q[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain_q[s] <= 1'b0;
                else     chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_db_setup.sv
module gpio_db_setup
    import gpio_db_pkg::*;
#(
    parameter int UNIT_T0 = 2,
    parameter int UNIT_T1 = 8,
    parameter int UNIT_T2 = 512,
    parameter int UNIT_T3 = 2048,
    parameter int TW      = 15
) (
    input  logic [DB_CNT_W-1:0] db_count,
    input  logic                db_unit_sel,
    input  logic                db_range_sel,
    input  logic [1:0]          db_type,
    output db_setup_t           eff,
    output logic [TW-1:0]       limit
);
    int ticks;

    always_comb begin
        eff.count     = db_count;
        eff.unit_sel  = db_unit_sel;
        eff.range_sel = db_range_sel;
        eff.mode      = flt_mode_e'(db_type);
        if (eff.mode != FLT_BYPASS && db_count == '0) begin
            eff.count     = DEF_COUNT;
            eff.unit_sel  = DEF_UNIT;
            eff.range_sel = DEF_RANGE;
            eff.mode      = FLT_REMOVE;
        end
        ticks = int'(eff.count) *
                unit_ticks(eff.range_sel, eff.unit_sel, UNIT_T0, UNIT_T1, UNIT_T2, UNIT_T3);
        limit = TW'(ticks);
    end
endmodule

// File: rtl/gpio_db_timer.sv
module gpio_db_timer #(
    parameter int TW = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          tick,
    input  logic [TW-1:0] limit,
    output logic          expired,
    output logic [TW-1:0] count_q
);
    logic [TW-1:0] count_inc;

    always_comb begin
        count_inc = count_q + TW'(1);
        expired   = tick && !clear && (count_inc >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst || clear)  count_q <= '0;
        else if (expired)  count_q <= '0;
        else if (tick)     count_q <= count_inc;
    end
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce
    import gpio_db_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int UNIT_T0     = 2,
    parameter int UNIT_T1     = 8,
    parameter int UNIT_T2     = 512,
    parameter int UNIT_T3     = 2048
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pin_raw,
    input  logic                rtc_tick,
    input  logic [DB_CNT_W-1:0] db_count,
    input  logic                db_unit_sel,
    input  logic                db_range_sel,
    input  logic [1:0]          db_type,
    output logic                pin_out
);
    localparam int MAX_LIMIT = ((1 << DB_CNT_W) - 1) * UNIT_T3;
    localparam int TIMER_W   = $clog2(MAX_LIMIT + 1);
    localparam int FILL_W    = $clog2(SYNC_STAGES + 2);
    localparam logic [FILL_W-1:0] FILL_DONE = FILL_W'(SYNC_STAGES + 1);

    logic               sync_q;
    db_setup_t          eff;
    logic [1:0]         eff_mode;
    logic [TIMER_W-1:0] limit;
    logic               tmr_clear;
    logic               tmr_expired;
    logic [TIMER_W-1:0] tmr_cnt;
    logic [FILL_W-1:0]  fill_q;
    logic               primed;
    logic               immediate;
    logic               out_q;

    gpio_db_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pin_raw),
        .dout (sync_q)
    );

    gpio_db_setup #(
        .UNIT_T0 (UNIT_T0),
        .UNIT_T1 (UNIT_T1),
        .UNIT_T2 (UNIT_T2),
        .UNIT_T3 (UNIT_T3),
        .TW      (TIMER_W)
    ) u_setup (
        .db_count     (db_count),
        .db_unit_sel  (db_unit_sel),
        .db_range_sel (db_range_sel),
        .db_type      (db_type),
        .eff          (eff),
        .limit        (limit)
    );

    gpio_db_timer #(.TW(TIMER_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (tmr_clear),
        .tick    (rtc_tick),
        .limit   (limit),
        .expired (tmr_expired),
        .count_q (tmr_cnt)
    );

    // priming: output tracks the synchroniser until it has filled
    always_ff @(posedge clk) begin
        if (rst)          fill_q <= '0;
        else if (!primed) fill_q <= fill_q + FILL_W'(1);
    end

    always_comb begin
        primed    = (fill_q == FILL_DONE);
        eff_mode  = eff.mode;
        immediate = passes_now(eff.mode, sync_q);
        tmr_clear = !primed || immediate || (sync_q == out_q);
    end

    always_ff @(posedge clk) begin
        if (rst)                       out_q <= 1'b0;
        else if (!primed || immediate) out_q <= sync_q;
        else if (tmr_expired)          out_q <= sync_q;
    end

    assign pin_out = out_q;
endmodule

// File: rtl/gpio_debounce_chk.sv
module gpio_debounce_chk #(
    parameter int TW = 15
) (
    input logic          clk,
    input logic          rst,
    input logic          pin_out,
    input logic          sync_q,
    input logic          primed,
    input logic [1:0]    mode,
    input logic [1:0]    cfg_type,
    input logic          expired,
    input logic [TW-1:0] timer_cnt
);
    // R1
    bypass_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_type == 2'd0) |=> (pin_out == $past(sync_q)));

    // R3
    remove_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (primed && mode == 2'd3 && !expired) |=> $stable(pin_out));

    // R3
    change_to_sync_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(pin_out) |-> (pin_out == $past(sync_q)));

    // R4
    timer_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (primed && sync_q == pin_out) |=> (timer_cnt == '0));

    // R5
    keep_low_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (primed && mode == 2'd1 && !sync_q) |=> !pin_out);

    // R6
    keep_high_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (primed && mode == 2'd2 && sync_q) |=> pin_out);
endmodule

bind gpio_debounce gpio_debounce_chk #(.TW(TIMER_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pin_out   (pin_out),
    .sync_q    (sync_q),
    .primed    (primed),
    .mode      (eff_mode),
    .cfg_type  (db_type),
    .expired   (tmr_expired),
    .timer_cnt (tmr_cnt)
);

// File: tb/sim_gpio_debounce.sv
module sim_gpio_debounce;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pin_raw = 1'b1;
    logic       rtc_tick = 1'b1;
    logic [3:0] db_count = 4'd15;
    logic       db_unit_sel = 1'b1;
    logic       db_range_sel = 1'b1;
    logic [1:0] db_type = 2'd3;
    logic       pin_out;

    int checks = 0;
    int errors = 0;
    logic cur = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_debounce u0 (
        .clk          (clk),
        .rst          (rst),
        .pin_raw      (pin_raw),
        .rtc_tick     (rtc_tick),
        .db_count     (db_count),
        .db_unit_sel  (db_unit_sel),
        .db_range_sel (db_range_sel),
        .db_type      (db_type),
        .pin_out      (pin_out)
    );

    function automatic int unit_of(input logic r, input logic u);
        if (r) return u ? 2048 : 512;
        return u ? 8 : 2;
    endfunction

    task automatic chk(input logic got, input logic exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic set_cfg(input logic [1:0] t, input logic [3:0] c, input logic r, input logic u);
        db_type = t; db_count = c; db_range_sel = r; db_unit_sel = u;
        @(negedge clk);
    endtask

    // drive a new level now (at a falling edge) and expect it on edge 'due'
    task automatic step(input logic lvl, input int due, input string req);
        pin_raw = lvl;
        repeat (due - 1) @(negedge clk);
        chk(pin_out, cur, req, "level held before due edge");
        @(negedge clk);
        chk(pin_out, lvl, req, "level at due edge");
        cur = lvl;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R8: reset with pin high and a very long timeout configured
        repeat (3) @(negedge clk);
        chk(pin_out, 1'b0, "R8", "output during reset");
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(pin_out, 1'b0, "R8", "output at second edge after reset");
        @(negedge clk);
        chk(pin_out, 1'b1, "R8", "output at third edge after reset");
        cur = 1'b1;

        // R1: bypass, steps and a one-cycle pulse
        set_cfg(2'd0, 4'd5, 1'b0, 1'b0);
        step(1'b0, 3, "R1");
        step(1'b1, 3, "R1");
        pin_raw = 1'b0;
        @(negedge clk);
        pin_raw = 1'b1;
        repeat (2) @(negedge clk);
        chk(pin_out, 1'b0, "R1", "one-cycle low pulse passes");
        @(negedge clk);
        chk(pin_out, 1'b1, "R1", "after pulse");

        // R2 and R3: sweep of counts and units in remove-glitch mode
        for (int r = 0; r < 2; r++) begin
            for (int u = 0; u < 2; u++) begin
                for (int c = 1; c < 16; c++) begin
                    if (r == 1 && c > 2) continue;
                    set_cfg(2'd3, 4'(c), 1'(r), 1'(u));
                    step(~cur, c * unit_of(1'(r), 1'(u)) + 2, "R2");
                    step(~cur, c * unit_of(1'(r), 1'(u)) + 2, "R3");
                end
            end
        end

        // R2: maximum timeout
        set_cfg(2'd3, 4'd15, 1'b1, 1'b1);
        step(~cur, 30722, "R2");

        // R3: excursion one tick short of the timeout (N = 6)
        set_cfg(2'd3, 4'd3, 1'b0, 1'b0);
        begin
            logic moved = 1'b0;
            pin_raw = ~cur;
            repeat (5) @(negedge clk);
            pin_raw = cur;
            repeat (15) begin
                @(negedge clk);
                if (pin_out !== cur) moved = 1'b1;
            end
            chk(moved, 1'b0, "R3", "short excursion ignored");
        end
        step(~cur, 8, "R3");

        // R4: partial count then a one-cycle return restarts the timeout
        pin_raw = ~cur;
        repeat (4) @(negedge clk);
        pin_raw = cur;
        @(negedge clk);
        step(~cur, 8, "R4");

        // R5: keep low pulses (N = 6)
        set_cfg(2'd1, 4'd3, 1'b0, 1'b0);
        if (cur == 1'b0) step(1'b1, 8, "R5");
        pin_raw = 1'b0;
        @(negedge clk);
        pin_raw = 1'b1;
        repeat (2) @(negedge clk);
        chk(pin_out, 1'b0, "R5", "low pulse passes at third edge");
        repeat (5) @(negedge clk);
        chk(pin_out, 1'b0, "R5", "rising edge still debouncing");
        @(negedge clk);
        chk(pin_out, 1'b1, "R5", "rising edge after timeout");
        cur = 1'b1;
        step(1'b0, 3, "R5");

        // R6: keep high pulses (N = 6)
        set_cfg(2'd2, 4'd3, 1'b0, 1'b0);
        pin_raw = 1'b1;
        @(negedge clk);
        pin_raw = 1'b0;
        repeat (2) @(negedge clk);
        chk(pin_out, 1'b1, "R6", "high pulse passes at third edge");
        repeat (5) @(negedge clk);
        chk(pin_out, 1'b1, "R6", "falling edge still debouncing");
        @(negedge clk);
        chk(pin_out, 1'b0, "R6", "falling edge after timeout");
        cur = 1'b0;
        step(1'b1, 3, "R6");

        // R7: zero count selects 15 x 8 ticks remove-glitch, even for type 1
        set_cfg(2'd1, 4'd0, 1'b1, 1'b0);
        step(1'b0, 122, "R7");
        step(1'b1, 122, "R7");

        // R9: no ticks, no debounced change (N = 2)
        set_cfg(2'd3, 4'd1, 1'b0, 1'b0);
        rtc_tick = 1'b0;
        pin_raw = ~cur;
        repeat (20) @(negedge clk);
        chk(pin_out, cur, "R9", "held without ticks");
        rtc_tick = 1'b1;
        @(negedge clk);
        chk(pin_out, cur, "R9", "one tick counted");
        @(negedge clk);
        chk(pin_out, ~cur, "R9", "change after two ticks");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule